// File: doc/BRIEF.md
# Supervisor Virtualization Intercept Unit

This unit sits beside the privileged-instruction decoder. It holds three supervisor-intercept control bits of the machine status register. The first traps address-translation management. The second bounds the wait-for-interrupt instruction with a timeout. The third traps the supervisor return. Each cycle the decoder presents the current privilege level and one-hot class strobes for the instruction it is decoding. The unit answers with an illegal-instruction pulse one cycle later when an enabled intercept applies.

A wait-for-interrupt that is accepted while no interrupt is pending starts a stall, and the unit reports the stall to pipeline control. The stall ends when an interrupt becomes pending. If the wait-for-interrupt ran below machine mode with the timeout bit set, a down-counter also runs. When the counter runs out first, the unit ends the stall and raises the exception. The control bits are written through a small write port and always read back as a legal value. A static configuration input says whether supervisor mode exists. When it does not, the two supervisor-only bits stay zero.

Top module: `svt_intercept`

## Requirements
- R1: After reset the control readback is 3'b000, `illegal_o` is 0 and `wfi_stall_o` is 0.
- R2: Privilege encoding: U=2'b00, S=2'b01, M=2'b11 (2'b10 counts as below M but not as S). An accepted access to the translation CSR or an accepted translation fence in S-mode, with control bit 0 (trap-translation) set, gives `illegal_o`=1 in the cycle after. In U-mode, or with the bit clear, it gives 0.
- R3: An accepted supervisor return in S-mode with control bit 2 (trap-return) set gives `illegal_o`=1 in the cycle after. With the bit clear, or in another mode, it gives 0.
- R4: No instruction accepted in M-mode raises `illegal_o`, whatever the control bits hold.
- R5: `illegal_o` is a registered pulse. It is raised only by an instruction sampled with `insn_valid_i`=1 or by a timeout. A trap lasts exactly one cycle unless a new trapping instruction follows.
- R6: A wait-for-interrupt accepted below M with control bit 1 (timeout-wait) set, and with no interrupt pending, holds `wfi_stall_o` high for WFI_LIMIT cycles. On the last of those edges `illegal_o` pulses and `wfi_stall_o` drops.
- R7: An interrupt pending during a stall ends it at the next edge without an exception. A wait-for-interrupt accepted while an interrupt is already pending does not stall.
- R8: A wait-for-interrupt in M-mode, or one accepted while bit 1 is clear, stalls until an interrupt is pending and never raises `illegal_o`.
- R9: Write port layout: bit 0 trap-translation, bit 1 timeout-wait, bit 2 trap-return. The readback shows the value last written, one cycle after the write. When `smode_present_i` is 0, bits 0 and 2 read 0 and writes to them are dropped, while bit 1 stays writable.
- R10: While `wfi_stall_o` is high, instruction strobes are ignored and do not raise `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smode_present_i | input | 1 | Static flag: supervisor mode implemented |
| priv_i | input | 2 | Current privilege level |
| insn_valid_i | input | 1 | Decoded instruction valid this cycle |
| is_atp_csr_i | input | 1 | Instruction reads or writes the translation CSR |
| is_atp_fence_i | input | 1 | Instruction is the translation fence |
| is_wfi_i | input | 1 | Instruction is wait-for-interrupt |
| is_sret_i | input | 1 | Instruction is supervisor return |
| ctl_we_i | input | 1 | Control bits write enable |
| ctl_wdata_i | input | 3 | Control bits write data |
| irq_pending_i | input | 1 | An enabled interrupt is pending |
| ctl_rdata_o | output | 3 | Legal control bits readback |
| illegal_o | output | 1 | Illegal-instruction exception pulse |
| wfi_stall_o | output | 1 | Wait-for-interrupt stall in progress |

## Verification
The trap decision is tried with each instruction class in U, S and M mode, with each control bit on and off. This separates the mode check from the bit check and the translation intercept from the return intercept. Wait-for-interrupt is run in three ways: with a timeout to the end, with an interrupt arriving partway, and with an interrupt already pending at issue. This separates the counter's limit from its cancel path. It is also run untimed, with the bit clear and in M-mode, where only an interrupt may end the stall. Writes of all-ones with supervisor mode absent show which bits are filtered, and trapping strobes applied during a stall show that they are ignored.

// File: rtl/svt_pkg.sv
package svt_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    localparam int CTL_W = 3;

    // bit 2: trap-return, bit 1: timeout-wait, bit 0: trap-translation
    typedef struct packed {
        logic trap_ret;
        logic wait_tmo;
        logic trap_xlat;
    } ctl_t;

    // bits that only exist when supervisor mode is implemented
    localparam logic [CTL_W-1:0] SMODE_ONLY_MASK = 3'b101;

    typedef struct packed {
        logic xlat_csr;
        logic xlat_fence;
        logic wfi;
        logic sret;
    } insn_cls_t;

endpackage

// File: rtl/svt_ctl_regs.sv
module svt_ctl_regs
    import svt_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  smode_present_i,
    input  logic  we_i,
    input  ctl_t  wdata_i,
    output ctl_t  ctl_o
);

    logic [CTL_W-1:0] legal_mask;
    ctl_t ctl_d, ctl_q;

    // per-bit legality: supervisor-only bits collapse to zero without S-mode
    for (genvar b = 0; b < CTL_W; b++) begin : g_mask
        if (SMODE_ONLY_MASK[b]) begin : g_smode
            assign legal_mask[b] = smode_present_i;
        end else begin : g_always
            assign legal_mask[b] = 1'b1;
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (we_i) begin
            ctl_d = wdata_i;
        end
        ctl_d = ctl_t'(ctl_d & legal_mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/svt_decode.sv
module svt_decode
    import svt_pkg::*;
(
    input  priv_e     priv_i,
    input  logic      valid_i,
    input  insn_cls_t cls_i,
    input  ctl_t      ctl_i,
    input  logic      busy_i,
    input  logic      irq_pending_i,
    output logic      trap_o,
    output logic      wfi_start_o,
    output logic      wfi_timed_o
);

    logic accept;
    logic in_smode;
    logic below_m;
    logic xlat_hit;
    logic ret_hit;

    always_comb begin
        accept      = valid_i && !busy_i;
        in_smode    = (priv_i == PRIV_S);
        below_m     = (priv_i != PRIV_M);
        xlat_hit    = ctl_i.trap_xlat && (cls_i.xlat_csr || cls_i.xlat_fence);
        ret_hit     = ctl_i.trap_ret && cls_i.sret;
        trap_o      = accept && in_smode && (xlat_hit || ret_hit);
        wfi_start_o = accept && cls_i.wfi && !irq_pending_i;
        wfi_timed_o = below_m && ctl_i.wait_tmo;
    end

endmodule

// File: rtl/svt_wfi_timer.sv
module svt_wfi_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic timed_i,
    input  logic irq_pending_i,
    output logic busy_o,
    output logic expire_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic             timed;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic last_tick;

    always_comb begin
        tmr_d     = tmr_q;
        last_tick = tmr_q.busy && tmr_q.timed && (tmr_q.cnt == CNT_LAST);
        expire_o  = last_tick && !irq_pending_i;
        if (tmr_q.busy) begin
            if (irq_pending_i || last_tick) begin
                tmr_d.busy  = 1'b0;
                tmr_d.timed = 1'b0;
                tmr_d.cnt   = '0;
            end else if (tmr_q.timed) begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            tmr_d.busy  = 1'b1;
            tmr_d.timed = timed_i;
            tmr_d.cnt   = CNT_LOAD;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o = tmr_q.busy;

endmodule

// File: rtl/svt_intercept.sv
module svt_intercept
    import svt_pkg::*;
#(
    parameter int WFI_LIMIT = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             smode_present_i,
    input  logic [1:0]       priv_i,
    input  logic             insn_valid_i,
    input  logic             is_atp_csr_i,
    input  logic             is_atp_fence_i,
    input  logic             is_wfi_i,
    input  logic             is_sret_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    input  logic             irq_pending_i,
    output logic [CTL_W-1:0] ctl_rdata_o,
    output logic             illegal_o,
    output logic             wfi_stall_o
);

    typedef struct packed {
        logic illegal;
    } top_t;

    top_t      top_d, top_q;
    ctl_t      ctl;
    insn_cls_t cls;
    logic      trap;
    logic      wfi_start;
    logic      wfi_timed;
    logic      busy;
    logic      expire;

    assign cls = '{xlat_csr:   is_atp_csr_i,
                   xlat_fence: is_atp_fence_i,
                   wfi:        is_wfi_i,
                   sret:       is_sret_i};

    svt_ctl_regs u_regs (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .smode_present_i(smode_present_i),
        .we_i           (ctl_we_i),
        .wdata_i        (ctl_t'(ctl_wdata_i)),
        .ctl_o          (ctl)
    );

    svt_decode u_dec (
        .priv_i       (priv_e'(priv_i)),
        .valid_i      (insn_valid_i),
        .cls_i        (cls),
        .ctl_i        (ctl),
        .busy_i       (busy),
        .irq_pending_i(irq_pending_i),
        .trap_o       (trap),
        .wfi_start_o  (wfi_start),
        .wfi_timed_o  (wfi_timed)
    );

    svt_wfi_timer #(.LIMIT(WFI_LIMIT)) u_tmr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (wfi_start),
        .timed_i      (wfi_timed),
        .irq_pending_i(irq_pending_i),
        .busy_o       (busy),
        .expire_o     (expire)
    );

    always_comb begin
        top_d         = top_q;
        top_d.illegal = trap || expire;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign illegal_o   = top_q.illegal;
    assign wfi_stall_o = busy;
    assign ctl_rdata_o = ctl;

endmodule

// File: rtl/svt_intercept_chk.sv
module svt_intercept_chk #(
    parameter int WFI_LIMIT = 64
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       smode_present_i,
    input logic [1:0] priv_i,
    input logic       insn_valid_i,
    input logic       is_atp_csr_i,
    input logic       is_atp_fence_i,
    input logic       is_sret_i,
    input logic       irq_pending_i,
    input logic [2:0] ctl_rdata_o,
    input logic       illegal_o,
    input logic       wfi_stall_o
);

    int stall_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stall_len <= 0;
        end else if (wfi_stall_o) begin
            stall_len <= stall_len + 1;
        end else begin
            stall_len <= 0;
        end
    end

    // R1: reset leaves no exception and no stall
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            a_reset_r1: assert (!illegal_o && !wfi_stall_o && ctl_rdata_o == 3'b000);
        end
    end

    p_xlat_trap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && !wfi_stall_o && priv_i == 2'b01 && ctl_rdata_o[0]
         && (is_atp_csr_i || is_atp_fence_i)) |=> illegal_o);

    p_ret_trap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && !wfi_stall_o && priv_i == 2'b01 && ctl_rdata_o[2]
         && is_sret_i) |=> illegal_o);

    p_mmode_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_valid_i && !wfi_stall_o && priv_i == 2'b11) |=> !illegal_o);

    p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!insn_valid_i && !wfi_stall_o) |=> !illegal_o);

    p_timeout_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(wfi_stall_o) && !$past(irq_pending_i)) |-> (illegal_o && stall_len == WFI_LIMIT));

    p_irq_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wfi_stall_o && irq_pending_i) |=> (!wfi_stall_o && !illegal_o));

    p_smode_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!smode_present_i && !$past(smode_present_i)) |-> (ctl_rdata_o[0] == 1'b0 && ctl_rdata_o[2] == 1'b0));

    p_stall_ignores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wfi_stall_o && irq_pending_i && insn_valid_i) |=> !illegal_o);

endmodule

bind svt_intercept svt_intercept_chk #(.WFI_LIMIT(WFI_LIMIT)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .smode_present_i(smode_present_i),
    .priv_i         (priv_i),
    .insn_valid_i   (insn_valid_i),
    .is_atp_csr_i   (is_atp_csr_i),
    .is_atp_fence_i (is_atp_fence_i),
    .is_sret_i      (is_sret_i),
    .irq_pending_i  (irq_pending_i),
    .ctl_rdata_o    (ctl_rdata_o),
    .illegal_o      (illegal_o),
    .wfi_stall_o    (wfi_stall_o)
);

// File: tb/svt_intercept_tb_top.sv
module svt_intercept_tb_top;

    localparam int LIM = 8;
    localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;
    localparam logic [3:0] C_NONE = 4'b0000, C_CSR = 4'b0001, C_FENCE = 4'b0010,
                           C_WFI = 4'b0100, C_SRET = 4'b1000;

    typedef struct {
        logic       ill;
        logic       stall;
        logic [2:0] rd;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smode = 1'b1;
    logic [1:0] priv = 2'b00;
    logic       valid = 1'b0;
    logic       c_csr = 1'b0, c_fence = 1'b0, c_wfi = 1'b0, c_sret = 1'b0;
    logic       we = 1'b0;
    logic [2:0] wdata = 3'b000;
    logic       irq = 1'b0;
    logic [2:0] rdata;
    logic       illegal;
    logic       stall;

    item_t q[$];
    logic [2:0] mdl = 3'b000;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    svt_intercept #(.WFI_LIMIT(LIM)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .smode_present_i(smode),
        .priv_i         (priv),
        .insn_valid_i   (valid),
        .is_atp_csr_i   (c_csr),
        .is_atp_fence_i (c_fence),
        .is_wfi_i       (c_wfi),
        .is_sret_i      (c_sret),
        .ctl_we_i       (we),
        .ctl_wdata_i    (wdata),
        .irq_pending_i  (irq),
        .ctl_rdata_o    (rdata),
        .illegal_o      (illegal),
        .wfi_stall_o    (stall)
    );

    task automatic step(input logic [1:0] p, input logic v, input logic [3:0] cls,
                        input logic w, input logic [2:0] wd, input logic ir,
                        input logic e_ill, input logic e_stall, input string req);
        item_t it;
        @(negedge clk);
        priv = p; valid = v;
        c_csr = cls[0]; c_fence = cls[1]; c_wfi = cls[2]; c_sret = cls[3];
        we = w; wdata = wd; irq = ir;
        if (w) mdl = wd;
        mdl = mdl & (smode ? 3'b111 : 3'b010);
        it.ill = e_ill; it.stall = e_stall; it.rd = mdl; it.req = req;
        q.push_back(it);
    endtask

    task automatic idle(input logic ir, input logic e_ill, input logic e_stall, input string req);
        step(PU, 1'b0, C_NONE, 1'b0, 3'b000, ir, e_ill, e_stall, req);
    endtask

    task automatic wr(input logic [2:0] wd, input string req);
        step(PU, 1'b0, C_NONE, 1'b1, wd, 1'b0, 1'b0, 1'b0, req);
    endtask

    // monitor: pop one expected item per cycle after the edge it belongs to
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (illegal !== it.ill || stall !== it.stall || rdata !== it.rd) begin
                n_fail++;
                $display("FAIL %s: ill/stall/rd actual %b/%b/%b expected %b/%b/%b",
                         it.req, illegal, stall, rdata, it.ill, it.stall, it.rd);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1'b0, 1'b0, 1'b0, "R1");
        // R2: bit clear -> no trap
        step(PS, 1'b1, C_CSR, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R2");
        wr(3'b001, "R9");
        step(PS, 1'b1, C_CSR, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, "R2");
        idle(1'b0, 1'b0, 1'b0, "R5");
        step(PS, 1'b1, C_FENCE, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, "R2");
        step(PU, 1'b1, C_CSR, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R2");
        step(PM, 1'b1, C_FENCE, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R4");
        step(PS, 1'b0, C_CSR, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R5");
        // R3 return intercept
        wr(3'b100, "R9");
        step(PS, 1'b1, C_SRET, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, "R3");
        step(PS, 1'b1, C_CSR, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R3");
        step(PU, 1'b1, C_SRET, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R3");
        step(PM, 1'b1, C_SRET, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R4");
        wr(3'b000, "R9");
        step(PS, 1'b1, C_SRET, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R3");
        // R6 timeout to the end
        wr(3'b010, "R9");
        step(PU, 1'b1, C_WFI, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, "R6");
        for (int i = 0; i < LIM - 1; i++) idle(1'b0, 1'b0, 1'b1, "R6");
        idle(1'b0, 1'b1, 1'b0, "R6");
        idle(1'b0, 1'b0, 1'b0, "R5");
        // R7 interrupt partway
        step(PS, 1'b1, C_WFI, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, "R7");
        idle(1'b0, 1'b0, 1'b1, "R7");
        idle(1'b0, 1'b0, 1'b1, "R7");
        idle(1'b1, 1'b0, 1'b0, "R7");
        // R7 pending at issue
        step(PU, 1'b1, C_WFI, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, "R7");
        // R8 M-mode wait, timeout bit set
        step(PM, 1'b1, C_WFI, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, "R8");
        for (int i = 0; i < LIM + 3; i++) idle(1'b0, 1'b0, 1'b1, "R8");
        idle(1'b1, 1'b0, 1'b0, "R8");
        // R8 timeout bit clear
        wr(3'b000, "R9");
        step(PU, 1'b1, C_WFI, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, "R8");
        for (int i = 0; i < LIM + 3; i++) idle(1'b0, 1'b0, 1'b1, "R8");
        idle(1'b1, 1'b0, 1'b0, "R8");
        // R10 strobes ignored during stall
        wr(3'b101, "R9");
        step(PU, 1'b1, C_WFI, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, "R10");
        step(PS, 1'b1, C_CSR, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, "R10");
        step(PS, 1'b1, C_SRET, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, "R10");
        idle(1'b1, 1'b0, 1'b0, "R10");
        step(PS, 1'b1, C_SRET, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, "R3");
        // R9 supervisor mode absent
        @(negedge clk);
        smode = 1'b0;
        wr(3'b111, "R9");
        step(PS, 1'b1, C_SRET, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R9");
        step(PS, 1'b1, C_CSR, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, "R9");
        wr(3'b000, "R9");
        idle(1'b0, 1'b0, 1'b0, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule